// File: doc/BRIEF.md
# Asynchronous Static Memory Port Controller

This block sits between a synchronous host and an external byte-wide asynchronous static memory. The host issues one word per request over a valid/ready handshake: an address, a write flag and, for writes, a data byte. The controller turns each request into a timed sequence on the memory pins: address, two chip enables (one active low, one active high), write strobe, output enable, and a split data bus. The bus is split into a data-out with its own output enable and a data-in. Completed reads return a byte together with a one-cycle valid strobe.

Every timing interval is a parameter counted in clock cycles. A clock period and the memory's timing table together fix the values. The parameters are the enable-to-strobe setup before a write pulse, the write pulse width, the hold after the pulse, the read access time and the bus turnaround after a read. The sequencer changes the address only in a cycle where both enables and the write strobe are inactive. Writes are controlled by the write strobe, which falls and rises inside a window where the enables are already active. A read always ends with idle cycles, so the host-side data driver never overlaps the memory's output.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, req_ready is 1, mem_ce1_n is 1, mem_ce2 is 0, mem_we_n is 1, mem_oe_n is 1, mem_dq_oe is 0 and rsp_valid is 0.
- R2: A request is taken at a clock edge where req_valid and req_ready are both 1. req_ready is then 0 from the next cycle until the transaction's last cycle has passed. It returns to 1 in the first idle cycle.
- R3: The cycle after acceptance presents the new mem_addr with the enables inactive. mem_addr holds its value for as long as the enables stay active.
- R4: A write holds the enables active (mem_ce1_n 0, mem_ce2 1) for SU_CYC cycles with mem_we_n 1. It then holds mem_we_n at 0 for exactly WP_CYC cycles, then keeps the enables active for HOLD_CYC cycles with mem_we_n 1. After that the enables return to inactive.
- R5: mem_dq_oe is 1 in exactly the cycles where a write holds the enables active, and mem_dq_out equals the accepted req_wdata there. mem_dq_oe is never 1 during a read.
- R6: A read holds the enables active and mem_oe_n at 0 for exactly RD_CYC cycles, with mem_we_n at 1 throughout.
- R7: A read samples mem_dq_in at the end of its last access cycle. In the next cycle, rsp_valid is 1 for exactly one cycle and rsp_rdata carries the sampled byte.
- R8: After a read's access cycles, the enables stay inactive for TURN_CYC cycles with req_ready 0 before the next request can be taken.
- R9: mem_oe_n is never 0 in a cycle where mem_we_n is 0 or mem_dq_oe is 1.
- R10: mem_ce2 is always the inverse of mem_ce1_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | Read data strobe, one cycle per read |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data returned by the memory |

## Verification
The read-data strobe falls in the first turnaround cycle. In that same cycle a held follow-on request, often a write, is already waiting on req_valid. The bench provokes this by queueing requests back to back with no gap, so the next request sits on the port while the strobe fires. The run passes only if rsp_rdata matches the reference memory in that cycle and the waiting request is not taken until the turnaround has ended. The memory model in the bench returns garbage except in the last access cycle, so a capture made one cycle early shows up as a data mismatch.

// File: rtl/sram_port_pkg.sv
// Package: shared sequencer state encoding for the static memory port controller.
package sram_port_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for a request, enables off
        ST_ADDR = 3'd1,   // new address applied, enables off
        ST_WSET = 3'd2,   // enables on, data driven, strobe high
        ST_WPUL = 3'd3,   // write strobe low
        ST_WHLD = 3'd4,   // strobe high again, enables and data held
        ST_RACC = 3'd5,   // enables and output enable on, access in progress
        ST_RTRN = 3'd6    // bus turnaround after a read
    } seq_state_t;
endpackage

// File: rtl/sram_seq_fsm.sv
// Module: sram_seq_fsm
// Walks one transaction through its timed phases. Every phase length comes
// from a parameter; each must be at least 1. Assumes start is only raised in
// ST_IDLE. Flags the last access cycle of a read for the data capture.
module sram_seq_fsm
    import sram_port_pkg::*;
#(
    parameter int SU_CYC   = 1,
    parameter int WP_CYC   = 3,
    parameter int HOLD_CYC = 1,
    parameter int RD_CYC   = 3,
    parameter int TURN_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       start_write,
    output seq_state_t state,
    output logic       capture
);
    localparam int MAX_A = (SU_CYC > WP_CYC) ? SU_CYC : WP_CYC;
    localparam int MAX_B = (HOLD_CYC > RD_CYC) ? HOLD_CYC : RD_CYC;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_L = (MAX_C > TURN_CYC) ? MAX_C : TURN_CYC;
    localparam int CW    = $clog2(MAX_L + 1);

    localparam logic [CW-1:0] SU_LAST   = CW'(SU_CYC - 1);
    localparam logic [CW-1:0] WP_LAST   = CW'(WP_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] RD_LAST   = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] TURN_LAST = CW'(TURN_CYC - 1);

    seq_state_t    nxt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    logic          done;
    logic          is_wr;

    // Purpose: pick the final count value for the current phase.
    always_comb begin
        case (state)
            ST_WSET: last = SU_LAST;
            ST_WPUL: last = WP_LAST;
            ST_WHLD: last = HOLD_LAST;
            ST_RACC: last = RD_LAST;
            ST_RTRN: last = TURN_LAST;
            default: last = '0;
        endcase
    end

    assign done    = (cnt == last);
    assign capture = (state == ST_RACC) && done;

    // Purpose: phase transition rules.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (start) nxt = ST_ADDR;
            ST_ADDR: nxt = is_wr ? ST_WSET : ST_RACC;
            ST_WSET: if (done) nxt = ST_WPUL;
            ST_WPUL: if (done) nxt = ST_WHLD;
            ST_WHLD: if (done) nxt = ST_IDLE;
            ST_RACC: if (done) nxt = ST_RTRN;
            ST_RTRN: if (done) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Purpose: state register and in-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
        end
    end

    // Purpose: remember the direction of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)     is_wr <= 1'b0;
        else if (start) is_wr <= start_write;
    end
endmodule

// File: rtl/sram_io_path.sv
// Module: sram_io_path
// Holds the address and write byte of the accepted request and captures the
// read byte. Assumes load and capture are never high in the same cycle.
module sram_io_path #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              capture,
    input  logic [DATA_W-1:0] rd_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rvalid_q
);
    // Purpose: latch request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (load) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    // Purpose: sample memory data at the end of access and strobe it out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (capture) rdata_q <= rd_in;
        end
    end
endmodule

// File: rtl/sram_port_ctrl.sv
// Module: sram_port_ctrl (top)
// Host-side controller for a byte-wide asynchronous static memory. Takes one
// request at a time and decodes the memory control pins from the phase
// state. Assumes the memory's data-in is settled by the end of RD_CYC cycles
// and that all phase parameters are at least 1.
module sram_port_ctrl
    import sram_port_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int SU_CYC   = 1,
    parameter int WP_CYC   = 3,
    parameter int HOLD_CYC = 1,
    parameter int RD_CYC   = 3,
    parameter int TURN_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    seq_state_t state;
    logic       capture;
    logic       accept;
    logic       enables_on;
    logic       wr_window;

    assign accept = req_valid && req_ready;

    sram_seq_fsm #(
        .SU_CYC  (SU_CYC),
        .WP_CYC  (WP_CYC),
        .HOLD_CYC(HOLD_CYC),
        .RD_CYC  (RD_CYC),
        .TURN_CYC(TURN_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .start_write(req_write),
        .state      (state),
        .capture    (capture)
    );

    sram_io_path #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_io (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .addr_in (req_addr),
        .wdata_in(req_wdata),
        .capture (capture),
        .rd_in   (mem_dq_in),
        .addr_q  (mem_addr),
        .wdata_q (mem_dq_out),
        .rdata_q (rsp_rdata),
        .rvalid_q(rsp_valid)
    );

    // Purpose: decode memory pins and handshake from the phase state.
    always_comb begin
        wr_window  = (state == ST_WSET) || (state == ST_WPUL) || (state == ST_WHLD);
        enables_on = wr_window || (state == ST_RACC);
        req_ready  = (state == ST_IDLE);
        mem_ce1_n  = !enables_on;
        mem_ce2    = enables_on;
        mem_we_n   = (state != ST_WPUL);
        mem_oe_n   = (state != ST_RACC);
        mem_dq_oe  = wr_window;
    end
endmodule

// File: rtl/sram_port_ctrl_chk.sv
// Module: sram_port_ctrl_chk
// Protocol checker bound to sram_port_ctrl; observes ports only.
module sram_port_ctrl_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce1_n,
    input logic              mem_ce2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    a_r10_ce_pair: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce2 == !mem_ce1_n);

    a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce1_n |=> (mem_ce1_n || $stable(mem_addr)));

    a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

    a_r4_strobe_inside: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce1_n && mem_dq_oe));

    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r3_enables_off_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_ce1_n);
endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_addr (mem_addr),
    .mem_ce1_n(mem_ce1_n),
    .mem_ce2  (mem_ce2),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_port_ctrl_test.sv
// Bench: per-cycle reference model built from queued expected pin patterns,
// plus a behavioural memory that only returns valid data late in an access.
module sram_port_ctrl_test;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int SU = 1, WP = 3, HD = 1, RD = 3, TN = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    always #4 clk = ~clk;

    sram_port_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SU_CYC(SU), .WP_CYC(WP),
                     .HOLD_CYC(HD), .RD_CYC(RD), .TURN_CYC(TN)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in));

    // Memory model: storage indexed by the low address byte; data valid only
    // in the last access cycle, garbage before that.
    logic [DW-1:0] smem [256];
    int            oe_cnt = 0;
    initial for (int i = 0; i < 256; i++) smem[i] = '0;
    always @(posedge clk) begin
        if (!mem_we_n && !mem_ce1_n && mem_ce2 && mem_dq_oe)
            smem[mem_addr[7:0]] <= mem_dq_out;
        oe_cnt <= (!mem_oe_n && !mem_ce1_n) ? oe_cnt + 1 : 0;
    end
    assign mem_dq_in = (!mem_oe_n && !mem_ce1_n && oe_cnt >= RD - 1)
                       ? smem[mem_addr[7:0]] : 8'hEE;

    // Expected per-cycle pattern: phase code plus pin expectations.
    typedef struct packed {
        logic [2:0] ph;   // 0 idle,1 addr,2 wset,3 wpul,4 whld,5 racc,6 rtrn
        logic rdy, ce, wel, oel, dqoe, rv;
    } cyc_t;
    cyc_t exp_q[$];

    typedef struct packed { logic wr; logic [AW-1:0] a; logic [DW-1:0] d; logic [3:0] gap; } rq_t;
    rq_t req_q[$];

    int checks = 0, errors = 0;
    logic [DW-1:0] ref_mem [int];
    logic [AW-1:0] cur_addr = '0;
    logic [DW-1:0] cur_wdata = '0;
    logic [DW-1:0] cur_rdata = '0;
    int gap_cnt = 0;

    function automatic string tag_of(input logic [2:0] ph);
        case (ph)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2, 3'd3, 3'd4: return "R4";
            3'd5: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
        end
    endtask

    function automatic cyc_t mk(input int ph, input bit rdy, ce, wel, oel, dqoe, rv);
        cyc_t c;
        c.ph = 3'(ph); c.rdy = rdy; c.ce = ce; c.wel = wel; c.oel = oel; c.dqoe = dqoe; c.rv = rv;
        return c;
    endfunction

    function automatic logic [AW-1:0] addr_of(input int lb);
        logic [8:0] up = 9'((lb * 37 + 5) % 512);
        return {up, 8'(lb)};
    endfunction

    task automatic push_txn(input rq_t r);
        exp_q.push_back(mk(1, 0, 0, 0, 0, 0, 0));
        if (r.wr) begin
            for (int i = 0; i < SU; i++) exp_q.push_back(mk(2, 0, 1, 0, 0, 1, 0));
            for (int i = 0; i < WP; i++) exp_q.push_back(mk(3, 0, 1, 1, 0, 1, 0));
            for (int i = 0; i < HD; i++) exp_q.push_back(mk(4, 0, 1, 0, 0, 1, 0));
            ref_mem[int'(r.a)] = r.d;
        end else begin
            for (int i = 0; i < RD; i++) exp_q.push_back(mk(5, 0, 1, 0, 1, 0, 0));
            exp_q.push_back(mk(6, 0, 0, 0, 0, 0, 1));
            for (int i = 1; i < TN; i++) exp_q.push_back(mk(6, 0, 0, 0, 0, 0, 0));
            cur_rdata = ref_mem.exists(int'(r.a)) ? ref_mem[int'(r.a)] : '0;
        end
        cur_addr  = r.a;
        cur_wdata = r.d;
    endtask

    // One cycle: compare outputs against the model, then drive the next input.
    task automatic step();
        cyc_t e;
        string t;
        @(negedge clk);
        e = (exp_q.size() > 0) ? exp_q.pop_front() : mk(0, 1, 0, 0, 0, 0, 0);
        t = tag_of(e.ph);
        chk(req_ready == e.rdy, t, "req_ready", int'(req_ready), int'(e.rdy));
        chk(mem_ce1_n == !e.ce, t, "mem_ce1_n", int'(mem_ce1_n), int'(!e.ce));
        chk(mem_ce2 == !mem_ce1_n, "R10", "mem_ce2", int'(mem_ce2), int'(!mem_ce1_n));
        chk(mem_we_n == !e.wel, "R4", "mem_we_n", int'(mem_we_n), int'(!e.wel));
        chk(mem_oe_n == !e.oel, "R6", "mem_oe_n", int'(mem_oe_n), int'(!e.oel));
        chk(mem_dq_oe == e.dqoe, "R5", "mem_dq_oe", int'(mem_dq_oe), int'(e.dqoe));
        chk(!(!mem_oe_n && (mem_dq_oe || !mem_we_n)), "R9", "contention", int'(mem_oe_n), 1);
        chk(rsp_valid == e.rv, "R7", "rsp_valid", int'(rsp_valid), int'(e.rv));
        if (e.ph != 3'd0)
            chk(mem_addr == cur_addr, "R3", "mem_addr", int'(mem_addr), int'(cur_addr));
        if (e.dqoe)
            chk(mem_dq_out == cur_wdata, "R5", "mem_dq_out", int'(mem_dq_out), int'(cur_wdata));
        if (e.rv)
            chk(rsp_rdata == cur_rdata, "R7", "rsp_rdata", int'(rsp_rdata), int'(cur_rdata));

        if (!req_valid && req_q.size() > 0) begin
            if (gap_cnt > 0) gap_cnt--;
            else begin
                req_valid = 1'b1;
                req_write = req_q[0].wr;
                req_addr  = req_q[0].a;
                req_wdata = req_q[0].d;
            end
        end
        if (req_valid && e.rdy) begin
            rq_t r = req_q.pop_front();
            push_txn(r);
            gap_cnt = (req_q.size() > 0) ? int'(req_q[0].gap) : 0;
        end else if (req_valid && exp_q.size() == 0 && !e.rdy) begin
            req_valid = 1'b1;
        end
        if (req_valid && exp_q.size() > 0 && exp_q[0].ph == 3'd1 && e.rdy) begin
            // accepted this cycle; release valid next cycle unless re-driven
        end
    endtask

    // Drop valid once the model shows the request was taken.
    always @(posedge clk) begin
        if (rst_n && req_valid && req_ready) begin
            #1 req_valid = 1'b0;
        end
    end

    function automatic rq_t mkr(input bit wr, input int lb, input int d, input int gap);
        rq_t r;
        r.wr = wr; r.a = addr_of(lb); r.d = 8'(d); r.gap = 4'(gap);
        return r;
    endfunction

    initial begin
        int cyc;
        // R1: reset values while reset is held
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(req_ready === 1'b1 && mem_ce1_n === 1'b1 && mem_ce2 === 1'b0 &&
                mem_we_n === 1'b1 && mem_oe_n === 1'b1 && mem_dq_oe === 1'b0 &&
                rsp_valid === 1'b0, "R1", "reset pins",
                int'({req_ready, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}),
                'b1101100);
        end
        // Directed: unwritten read, write/read, read then write back to back, extremes
        req_q.push_back(mkr(0, 3, 0, 0));
        req_q.push_back(mkr(1, 3, 'h5A, 0));
        req_q.push_back(mkr(0, 3, 0, 0));
        req_q.push_back(mkr(1, 0, 'hA5, 0));
        req_q.push_back(mkr(1, 255, 'hFF, 2));
        req_q.push_back(mkr(0, 255, 0, 0));
        req_q.push_back(mkr(1, 7, 'h00, 0));
        req_q.push_back(mkr(0, 0, 0, 3));
        req_q.push_back(mkr(0, 7, 0, 0));
        for (int i = 0; i < 40; i++)
            req_q.push_back(mkr($urandom_range(0, 1), $urandom_range(0, 15),
                                $urandom_range(0, 255), $urandom_range(0, 2)));
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        while ((req_q.size() > 0 || exp_q.size() > 0 || req_valid) && cyc < 20000) begin
            step();
            cyc++;
        end
        for (int i = 0; i < 4; i++) step();
        if (cyc >= 20000) begin
            checks++; errors++;
            $display("FAIL R2 watchdog actual=%0d expected<%0d", cyc, 20000);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule